// File: doc/BRIEF.md
# SD Card SPI-Mode Block Write Engine

This engine runs the data phase of a write to an SD card that is in SPI mode. It starts once the write command has been accepted by the card. For each block it sends an idle filler byte and a start token. It then streams the block's bytes from a local buffer and appends a CRC16 that it computes as the bytes go out. After that it looks for the card's data-response token and waits for the card to finish programming. When all blocks of a multi-block write have succeeded, it sends the stop-transfer token and waits for busy once more. It then reports one of three results: success, rejection, or timeout.

The engine does not drive SPI pins. It talks to an external byte shifter through a request/done exchange: each request carries one byte to send, and each done returns the byte received in the same exchange. Block size and block count are sampled at start. Buffer addresses run from zero upward across all blocks of one transfer. The buffer read is combinational, so `buf_data` must follow `buf_addr` within the same cycle.

Top module: `sd_spi_blk_writer`

## Requirements
- R1: Each block begins with byte 0xFF and then a start token: 0xFC when `multi` is 1, 0xFE when it is 0. The block's data bytes follow, read from buffer addresses that continue from 0 across blocks.
- R2: After the data, the CRC16 of that block's data is sent high byte first. The CRC uses polynomial 0x1021, starts from 0 and takes bits MSB first.
- R3: After the CRC the engine sends 0xFF up to 8 times, looking for a received byte with bit 4 clear. If none of the 8 bytes has bit 4 clear, the transfer ends with status 1.
- R4: A response byte whose low five bits equal 0x05 means the block was accepted. Any other value of a byte with bit 4 clear ends the transfer with status 1, and no further byte is sent.
- R5: After acceptance the engine sends 0xFF polls until a received 0xFF ends busy. A 0xFF received on the first poll does not count.
- R6: If BUSY_LIMIT polls pass without the end of busy, the transfer ends with status 2.
- R7: Only a multi-block transfer whose blocks all succeeded sends 0xFF and then 0xFD afterwards, followed by the same busy wait. A single-block transfer never sends them, and neither does a failed one.
- R8: At most one byte exchange is outstanding. `sx_req` is a one-cycle pulse, and the next request comes only after `sx_done`.
- R9: `done` pulses for one cycle at the end of a transfer. `err_code` (0 ok, 1 rejected, 2 timeout) is then valid and holds until the next start. `busy` is high from start until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer; sampled when idle |
| multi | input | 1 | 1 = multi-block token and stop sequence |
| blk_size | input | SIZE_W | Data bytes per block, at least 1 |
| blk_count | input | COUNT_W | Number of blocks, at least 1 |
| buf_addr | output | ADDR_W | Buffer read address |
| buf_data | input | 8 | Buffer byte at `buf_addr`, same cycle |
| sx_req | output | 1 | Byte exchange request pulse |
| sx_tx | output | 8 | Byte to send, valid with `sx_req` |
| sx_done | input | 1 | Byte exchange finished |
| sx_rx | input | 8 | Byte received, valid with `sx_done` |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err_code | output | 2 | Result: 0 ok, 1 rejected, 2 timeout |

## Verification
The assertions assume the shifter never returns `sx_done` without an outstanding request. They also assume that `blk_size` and `blk_count` are non-zero at start. The bench's card model answers each request only after a delay of one to three cycles, and it never signals done unprompted. The bench draws block sizes from 1 to 12 and counts from 1 to 4. Directed cases aim at the 8-byte response window, the ignored first busy poll and the poll limit, which the bench sets to 40.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
   typedef enum logic [1:0] {
      SDW_OK      = 2'd0,
      SDW_REJECT  = 2'd1,
      SDW_TIMEOUT = 2'd2
   } sdw_status_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PRE,
      ST_TOK,
      ST_DATA,
      ST_CRCH,
      ST_CRCL,
      ST_RESP,
      ST_BUSYW,
      ST_SPRE,
      ST_STOK
   } sdw_state_e;

   localparam logic [7:0] FILL_BYTE   = 8'hFF;
   localparam logic [7:0] TOK_SINGLE  = 8'hFE;
   localparam logic [7:0] TOK_MULTI   = 8'hFC;
   localparam logic [7:0] TOK_STOP    = 8'hFD;
   localparam logic [4:0] RESP_ACCEPT = 5'h05;
endpackage

// File: rtl/sdw_crc16.sv
module sdw_crc16 (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        en,
   input  logic [7:0]  din,
   output logic [15:0] crc
);
   localparam logic [15:0] POLY = 16'h1021;

   function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      r = c;
      for (int i = 7; i >= 0; i--) begin
         if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ POLY;
         else              r = {r[14:0], 1'b0};
      end
      return r;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc <= '0;
      else if (clr) crc <= '0;
      else if (en)  crc <= crc_byte(crc, din);
   end

   AST_CRC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (crc == 16'h0000)); // R2
endmodule

// File: rtl/sdw_limit_ctr.sv
module sdw_limit_ctr #(
   parameter int LIMIT = 8,
   parameter int W     = $clog2(LIMIT + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt,
   output logic         last
);
   initial begin
      assert (LIMIT >= 2) else $error("sdw_limit_ctr: LIMIT must be at least 2");
   end

   assign last = (cnt == W'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + W'(1);
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt <= W'(LIMIT - 1)); // R6
   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) inc |-> !last); // R3
endmodule

// File: rtl/sdw_resp_decode.sv
module sdw_resp_decode (
   input  logic [7:0] rx,
   output logic       is_token,
   output logic       accepted,
   output logic       busy_free
);
   import sdw_pkg::*;
   assign is_token  = ~rx[4];
   assign accepted  = ~rx[4] && (rx[4:0] == RESP_ACCEPT);
   assign busy_free = (rx == FILL_BYTE);
endmodule

// File: rtl/sd_spi_blk_writer.sv
module sd_spi_blk_writer
   import sdw_pkg::*;
#(
   parameter int SIZE_W     = 10,
   parameter int COUNT_W    = 16,
   parameter int ADDR_W     = 20,
   parameter int RESP_TRIES = 8,
   parameter int BUSY_LIMIT = 3000000,
   parameter bit CRC_ON     = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               multi,
   input  logic [SIZE_W-1:0]  blk_size,
   input  logic [COUNT_W-1:0] blk_count,
   output logic [ADDR_W-1:0]  buf_addr,
   input  logic [7:0]         buf_data,
   output logic               sx_req,
   output logic [7:0]         sx_tx,
   input  logic               sx_done,
   input  logic [7:0]         sx_rx,
   output logic               busy,
   output logic               done,
   output logic [1:0]         err_code
);
   localparam int RESP_W = $clog2(RESP_TRIES + 1);
   localparam int POLL_W = $clog2(BUSY_LIMIT + 1);

   initial begin
      assert (SIZE_W >= 1)       else $error("SIZE_W must be at least 1");
      assert (COUNT_W >= 1)      else $error("COUNT_W must be at least 1");
      assert (ADDR_W >= SIZE_W)  else $error("ADDR_W must cover one block");
      assert (RESP_TRIES >= 2)   else $error("RESP_TRIES must be at least 2");
      assert (BUSY_LIMIT >= 2)   else $error("BUSY_LIMIT must be at least 2");
   end

   sdw_state_e          state_q;
   logic                pend_q;
   logic                multi_q;
   logic [SIZE_W-1:0]   size_q;
   logic [SIZE_W-1:0]   bcnt_q;
   logic [COUNT_W-1:0]  left_q;
   logic [ADDR_W-1:0]   addr_q;
   logic                stop_q;
   logic                done_q;
   sdw_status_e         err_q;

   logic                xfer_ok;
   logic                is_token, accepted, busy_free;
   logic [RESP_W-1:0]   resp_cnt;
   logic                resp_last;
   logic [POLL_W-1:0]   poll_cnt;
   logic                poll_last;
   logic                busy_end;
   logic [15:0]         crc;
   logic                last_byte, last_blk;

   assign xfer_ok   = sx_done && pend_q;
   assign busy_end  = (poll_cnt != '0) && busy_free;
   assign last_byte = ((bcnt_q + SIZE_W'(1)) == size_q);
   assign last_blk  = (left_q == COUNT_W'(1));

   sdw_resp_decode u_dec (
      .rx        (sx_rx),
      .is_token  (is_token),
      .accepted  (accepted),
      .busy_free (busy_free)
   );

   sdw_limit_ctr #(.LIMIT(RESP_TRIES), .W(RESP_W)) u_resp_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state_q != ST_RESP),
      .inc   (xfer_ok && (state_q == ST_RESP) && !is_token && !resp_last),
      .cnt   (resp_cnt),
      .last  (resp_last)
   );

   sdw_limit_ctr #(.LIMIT(BUSY_LIMIT), .W(POLL_W)) u_poll_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state_q != ST_BUSYW),
      .inc   (xfer_ok && (state_q == ST_BUSYW) && !busy_end && !poll_last),
      .cnt   (poll_cnt),
      .last  (poll_last)
   );

   generate
      if (CRC_ON) begin : g_crc
         sdw_crc16 u_crc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (state_q == ST_TOK),
            .en    (sx_req && (state_q == ST_DATA)),
            .din   (buf_data),
            .crc   (crc)
         );
      end else begin : g_nocrc
         assign crc = 16'hFFFF;
      end
   endgenerate

   assign sx_req   = (state_q != ST_IDLE) && !pend_q;
   assign buf_addr = addr_q;
   assign busy     = (state_q != ST_IDLE);
   assign done     = done_q;
   assign err_code = err_q;

   always_comb begin
      unique case (state_q)
         ST_TOK:  sx_tx = multi_q ? TOK_MULTI : TOK_SINGLE;
         ST_STOK: sx_tx = TOK_STOP;
         ST_DATA: sx_tx = buf_data;
         ST_CRCH: sx_tx = crc[15:8];
         ST_CRCL: sx_tx = crc[7:0];
         default: sx_tx = FILL_BYTE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= 1'b0;
         multi_q <= 1'b0;
         size_q  <= '0;
         bcnt_q  <= '0;
         left_q  <= '0;
         addr_q  <= '0;
         stop_q  <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= SDW_OK;
      end else begin
         done_q <= 1'b0;
         if (sx_req)       pend_q <= 1'b1;
         else if (sx_done) pend_q <= 1'b0;

         if (state_q == ST_IDLE) begin
            if (start) begin
               state_q <= ST_PRE;
               multi_q <= multi;
               size_q  <= blk_size;
               left_q  <= blk_count;
               addr_q  <= '0;
               bcnt_q  <= '0;
               stop_q  <= 1'b0;
               err_q   <= SDW_OK;
            end
         end else if (xfer_ok) begin
            unique case (state_q)
               ST_PRE:  state_q <= ST_TOK;
               ST_TOK:  state_q <= ST_DATA;
               ST_DATA: begin
                  addr_q <= addr_q + ADDR_W'(1);
                  if (last_byte) begin
                     bcnt_q  <= '0;
                     state_q <= ST_CRCH;
                  end else begin
                     bcnt_q <= bcnt_q + SIZE_W'(1);
                  end
               end
               ST_CRCH: state_q <= ST_CRCL;
               ST_CRCL: state_q <= ST_RESP;
               ST_RESP: begin
                  if (is_token) begin
                     if (accepted) begin
                        state_q <= ST_BUSYW;
                     end else begin
                        state_q <= ST_IDLE;
                        err_q   <= SDW_REJECT;
                        done_q  <= 1'b1;
                     end
                  end else if (resp_last) begin
                     state_q <= ST_IDLE;
                     err_q   <= SDW_REJECT;
                     done_q  <= 1'b1;
                  end
               end
               ST_BUSYW: begin
                  if (busy_end) begin
                     if (stop_q || (last_blk && !multi_q)) begin
                        state_q <= ST_IDLE;
                        err_q   <= SDW_OK;
                        done_q  <= 1'b1;
                     end else if (last_blk) begin
                        state_q <= ST_SPRE;
                     end else begin
                        left_q  <= left_q - COUNT_W'(1);
                        state_q <= ST_PRE;
                     end
                  end else if (poll_last) begin
                     state_q <= ST_IDLE;
                     err_q   <= SDW_TIMEOUT;
                     done_q  <= 1'b1;
                  end
               end
               ST_SPRE: state_q <= ST_STOK;
               ST_STOK: begin
                  stop_q  <= 1'b1;
                  state_q <= ST_BUSYW;
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n) sx_done |-> pend_q); // R8
   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) sx_req |=> !sx_req); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
   AST_STOP_AFTER_ALL: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_STOK) |-> (multi_q && last_blk && (err_q == SDW_OK))); // R7
   AST_FIRST_POLL_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (xfer_ok && state_q == ST_BUSYW && poll_cnt == '0) |=> (state_q == ST_BUSYW)); // R5
endmodule

// File: tb/sd_spi_blk_writer_tb_top.sv
module sd_spi_blk_writer_tb_top;
   localparam int LIM    = 40;
   localparam int MAXCAP = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        multi = 1'b0;
   logic [9:0]  blk_size = '0;
   logic [15:0] blk_count = '0;
   logic [19:0] buf_addr;
   logic [7:0]  buf_data;
   logic        sx_req;
   logic [7:0]  sx_tx;
   logic        sx_done = 1'b0;
   logic [7:0]  sx_rx = 8'h00;
   logic        busy, done;
   logic [1:0]  err_code;

   always #5 clk = ~clk;

   sd_spi_blk_writer #(.BUSY_LIMIT(LIM)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .multi(multi),
      .blk_size(blk_size), .blk_count(blk_count),
      .buf_addr(buf_addr), .buf_data(buf_data),
      .sx_req(sx_req), .sx_tx(sx_tx), .sx_done(sx_done), .sx_rx(sx_rx),
      .busy(busy), .done(done), .err_code(err_code)
   );

   int nchk = 0, nfail = 0;
   int salt = 0;
   bit hung = 0;

   // scenario: index nblk is the stop-phase busy wait
   int         k_a [0:8];
   logic [7:0] tok_a [0:8];
   logic [7:0] fb_a [0:8];
   int         nb_a [0:8];
   int         nblk, bsz;
   bit         mflag;

   logic [7:0] exp_b [0:MAXCAP-1];
   logic [7:0] cap_b [0:MAXCAP-1];
   int exp_n, cap_n, exp_err, proto_bad;
   int mphase, mcnt, mblk;

   function automatic logic [7:0] dval(input int a, input int s);
      return 8'((a * 37 + s) & 255);
   endfunction

   assign buf_data = dval(int'(buf_addr), salt);

   function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r = c;
      for (int i = 7; i >= 0; i--) r = (r[15] ^ d[i]) ? ({r[14:0], 1'b0} ^ 16'h1021) : {r[14:0], 1'b0};
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic push(input logic [7:0] b);
      if (exp_n < MAXCAP) exp_b[exp_n] = b;
      exp_n++;
   endtask

   // returns 0 if busy ended, 2 on timeout
   task automatic exp_busy(input int idx, output int r);
      int polls = nb_a[idx] + 2;
      r = 0;
      if (polls > LIM) begin polls = LIM; r = 2; end
      for (int i = 0; i < polls; i++) push(8'hFF);
   endtask

   task automatic build_expect();
      int a = 0;
      int r;
      logic [15:0] c;
      exp_n = 0;
      exp_err = 0;
      for (int b = 0; b < nblk; b++) begin
         push(8'hFF);
         push(mflag ? 8'hFC : 8'hFE);
         c = 16'h0000;
         for (int i = 0; i < bsz; i++) begin
            push(dval(a, salt));
            c = crc_upd(c, dval(a, salt));
            a++;
         end
         push(c[15:8]);
         push(c[7:0]);
         if (k_a[b] >= 8) begin
            for (int i = 0; i < 8; i++) push(8'hFF);
            exp_err = 1;
            return;
         end
         for (int i = 0; i <= k_a[b]; i++) push(8'hFF);
         if (tok_a[b][4:0] != 5'h05) begin exp_err = 1; return; end
         exp_busy(b, r);
         if (r != 0) begin exp_err = r; return; end
      end
      if (mflag) begin
         push(8'hFF);
         push(8'hFD);
         exp_busy(nblk, r);
         exp_err = r;
      end
   endtask

   task automatic card_reply(output logic [7:0] rsp);
      int flen;
      rsp = 8'hFF;
      if (mphase == 0) begin
         flen = (mblk < nblk) ? bsz + 4 : 2;
         mcnt++;
         if (mcnt == flen) begin
            mcnt = 0;
            mphase = (mblk < nblk) ? 1 : 2;
         end
      end else if (mphase == 1) begin
         if (k_a[mblk] < 8 && mcnt >= k_a[mblk]) rsp = tok_a[mblk];
         mcnt++;
         if (!rsp[4]) begin mphase = 2; mcnt = 0; end
      end else if (mphase == 2) begin
         if (mcnt == 0) rsp = fb_a[mblk];
         else if (mcnt <= nb_a[mblk]) rsp = 8'h00;
         if (mcnt >= 1 && rsp == 8'hFF) begin
            mblk++;
            mcnt = 0;
            mphase = (mblk <= nblk) ? 0 : 3;
         end else mcnt++;
      end
   endtask

   // card model: answers each request after 1..3 cycles
   initial begin
      logic [7:0] rsp;
      int dly;
      forever begin
         @(negedge clk);
         sx_done = 1'b0;
         if (rst_n && sx_req) begin
            if (cap_n < MAXCAP) cap_b[cap_n] = sx_tx;
            cap_n++;
            card_reply(rsp);
            dly = $urandom_range(1, 3);
            for (int d = 0; d < dly; d++) begin
               @(negedge clk);
               if (sx_req) proto_bad++;
            end
            sx_rx = rsp;
            sx_done = 1'b1;
         end
      end
   end

   task automatic run(input string tag);
      int cyc = 0;
      int mism = 0;
      string rq;
      if (hung) return;
      build_expect();
      mphase = 0; mcnt = 0; mblk = 0; cap_n = 0; proto_bad = 0;
      @(negedge clk);
      multi = mflag;
      blk_size = 10'(bsz);
      blk_count = 16'(nblk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R9 busy after start", busy, 1);
      while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
      if (!done) begin
         hung = 1;
         check(0, "R9 watchdog", 0, 1);
         return;
      end
      rq = (exp_err == 2) ? "R6 status" : (exp_err == 1) ? "R3 R4 status" : "R9 status";
      check(int'(err_code) == exp_err, {tag, " ", rq}, err_code, exp_err);
      check(cap_n == exp_n, {tag, " R5 R7 byte count"}, cap_n, exp_n);
      for (int i = 0; i < exp_n && i < cap_n && i < MAXCAP; i++)
         if (cap_b[i] !== exp_b[i]) begin
            if (mism == 0) $display("  first mismatch at byte %0d: %h vs %h", i, cap_b[i], exp_b[i]);
            mism++;
         end
      check(mism == 0, {tag, " R1 R2 byte stream mismatches"}, mism, 0);
      check(proto_bad == 0, {tag, " R8 request while outstanding"}, proto_bad, 0);
      @(negedge clk);
      check(!done && int'(err_code) == exp_err, {tag, " R9 done pulse and held status"}, done, 0);
   endtask

   task automatic good_all();
      for (int i = 0; i <= 8; i++) begin
         k_a[i] = 0; tok_a[i] = 8'hE5; fb_a[i] = 8'h00; nb_a[i] = 2;
      end
   endtask

   initial begin
      int wd = 0;
      forever begin
         @(posedge clk);
         wd++;
         if (wd > 190000) begin
            nfail++; nchk++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 190000);
            $display("Result: errors=%0d of %0d checks", nfail, nchk);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check(!busy && !done && !sx_req, "R9 reset idle", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !sx_req && err_code == 2'd0, "R8 idle after reset", sx_req, 0);

      // single block, first poll 0xFF ignored
      good_all(); salt = 3; nblk = 1; bsz = 4; mflag = 0; fb_a[0] = 8'hFF; nb_a[0] = 3;
      run("single");
      // immediate end of busy on second poll
      good_all(); salt = 9; nblk = 1; bsz = 1; mflag = 0; fb_a[0] = 8'hFF; nb_a[0] = 0;
      run("size1 fastbusy R5");
      // multi with stop sequence
      good_all(); salt = 17; nblk = 3; bsz = 5; mflag = 1; k_a[1] = 7; k_a[2] = 2; nb_a[3] = 4;
      run("multi R7");
      // CRC-error token on block 2, no stop sent
      good_all(); salt = 21; nblk = 3; bsz = 3; mflag = 1; tok_a[1] = 8'h0B;
      run("crc token R4");
      // write-error token
      good_all(); salt = 22; nblk = 1; bsz = 6; mflag = 0; tok_a[0] = 8'h0D;
      run("write err R4");
      // no token within window
      good_all(); salt = 30; nblk = 2; bsz = 2; mflag = 1; k_a[0] = 8;
      run("no token R3");
      // token on last allowed byte
      good_all(); salt = 31; nblk = 1; bsz = 2; mflag = 0; k_a[0] = 7;
      run("token at 8th R3");
      // busy timeout in block
      good_all(); salt = 40; nblk = 2; bsz = 3; mflag = 1; nb_a[1] = 50;
      run("block timeout R6");
      // busy timeout after stop token
      good_all(); salt = 41; nblk = 2; bsz = 3; mflag = 1; nb_a[2] = 39;
      run("stop timeout R6");
      // exactly at limit: ends on the last allowed poll
      good_all(); salt = 42; nblk = 1; bsz = 2; mflag = 0; nb_a[0] = 38;
      run("limit edge R6");
      // single-mode, several blocks, no stop token
      good_all(); salt = 43; nblk = 3; bsz = 4; mflag = 0;
      run("single-token multi-count R7");

      for (int t = 0; t < 25; t++) begin
         salt = $urandom_range(0, 255);
         nblk = $urandom_range(1, 4);
         bsz = $urandom_range(1, 12);
         mflag = 1'($urandom_range(0, 1));
         for (int i = 0; i <= 8; i++) begin
            int p = $urandom_range(0, 19);
            k_a[i] = (p == 0) ? 9 : $urandom_range(0, 4);
            tok_a[i] = (p == 1) ? 8'h0B : (p == 2) ? 8'h0D : 8'hE5;
            fb_a[i] = $urandom_range(0, 1) ? 8'hFF : 8'h00;
            nb_a[i] = (p == 3) ? 45 : $urandom_range(0, 10);
         end
         run("random");
      end

      $display("Result: errors=%0d of %0d checks", nfail, nchk);
      $finish;
   end
endmodule